// File: doc/BRIEF.md
# Set-Associative Write-Through Data Cache

This block sits between a load/store unit and a memory port that is one 32-bit word wide. It serves byte, halfword and word loads and stores. It is built from parameterised sets, ways and line length, and each of these counts must be a power of two. Lanes inside a word are big-endian.

Every store is written through to memory before the cache is looked at. A miss on a load or a store allocates a line. The victim comes from a per-set age-counter replacement unit. The line is then filled one word at a time, starting with the word that was asked for. If the cache is absent or disabled, or the access carries the no-cache flag, the access goes straight to memory and the arrays and counters are left alone. An invalidate command clears either one matching way or a whole set, depending on the configuration inputs. Four counters record read hits, read misses, write hits and write misses.

The requester raises `cpu_req` and holds its inputs steady until `cpu_ready` pulses for one cycle. It must keep `cfg_present` and `cfg_enable` stable while an access is in flight. The memory side has one word outstanding at a time. `mem_req` stays high until a one-cycle `mem_ack` arrives, and `mem_err` can be raised alongside that acknowledge.

Top module: `dcache_wt`

## Requirements
- R1: The line offset is the low log2(LINE_WORDS*4) address bits. The set index is (address / line bytes) mod SETS, and the tag is the remaining upper bits. A load that hits returns the cached copy even when memory has changed behind the cache.
- R2: When `cfg_present` is 0, `cfg_enable` is 0 or `cpu_nocache` is 1, a load performs exactly one word read at the aligned address, and a store performs only its memory write. The arrays, ages and counters are left unchanged.
- R3: A store first issues exactly one memory write. It carries a lane mask `mem_be`, where bit 3 selects bits 31:24 and bit 0 selects bits 7:0, together with the lane data. An error on that write ends the store with `cpu_err`=1 and no cache update.
- R4: `cpu_size` encodes 0 as byte, 1 as halfword and 2 as word. Lanes are big-endian: byte offset 0 is bits 31:24, and a halfword at offset 0 is bits 31:16. A load returns its lane zero-extended.
- R5: A store that hits replaces only its own lane in the cached word. Later loads see the merged value.
- R6: A refill reads LINE_WORDS words. It starts at the word holding the requested address and steps up by one word, wrapping within the line.
- R7: A load miss and a cacheable store miss both allocate. The victim is the lowest-numbered way whose age is the smallest value below the top age (USTATES-1), or way 0 if no way is below the top age.
- R8: On a hit, every way of the set that is older than the hit way steps down by one, and the hit way goes to the top age. On a completed refill, every nonzero age in the set steps down by one, and the filled way goes to the top age.
- R9: A bus error during refill leaves the victim way invalid with age 0, and the access ends with `cpu_err`=1 and `cpu_rdata`=0. The same holds for an erroring bypass load.
- R10: When the cache is absent, an invalidate does nothing. When it is present but disabled, an invalidate clears every way of the indexed set. Otherwise it clears only a matching valid way. An invalidate makes no memory access.
- R11: The four counters advance by one on, respectively, a cacheable load hit, a load miss, a cacheable store hit after a successful memory write, and a store miss. Nothing else changes them, and they reset to 0.
- R12: `cpu_ready` is a one-cycle pulse that ends each access. `mem_req` and `mem_addr` hold steady until `mem_ack`. After reset, `cpu_ready` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_present | input | 1 | Cache exists |
| cfg_enable | input | 1 | Cache enabled |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data, right-aligned |
| cpu_nocache | input | 1 | Access is cache-inhibited |
| cpu_inv | input | 1 | Request is an invalidate of cpu_addr |
| cpu_ready | output | 1 | Access complete (one cycle) |
| cpu_rdata | output | 32 | Load result, zero-extended |
| cpu_err | output | 1 | Access ended with a bus error |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Lane mask for writes, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane data for writes |
| mem_ack | input | 1 | Memory word done |
| mem_rdata | input | 32 | Memory read word |
| mem_err | input | 1 | Bus error with the acknowledge |
| cnt_rd_hit | output | CNT_W | Read hit count |
| cnt_rd_miss | output | CNT_W | Read miss count |
| cnt_wr_hit | output | CNT_W | Write hit count |
| cnt_wr_miss | output | CNT_W | Write miss count |

## Verification
Directed traffic covers several cases, each isolating one behaviour:
- Repeated lines in one set separate hits from misses. A backdoor change to memory then shows that a hit returns the cached copy, not the memory value.
- A third tag in a two-way set reveals which way the age counters pick as victim.
- Misses at the first and the last word of a line show the wrap order of the refill address sequence.
- Cacheable, no-cache, disabled and absent configurations are run through loads, stores and invalidates, so bypass and the three invalidate modes can be told apart.
- Injected errors on a store write and mid-refill show the error path.

A long run of random sizes, offsets, tags and configuration flips is then compared against a behavioural reference of arrays, ages and a memory map. The comparison covers every result, every memory address sequence and every counter.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISP,
        ST_MEMRD,
        ST_MEMWR,
        ST_LOOK,
        ST_FILL,
        ST_DONE
    } dc_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/dc_lane.sv
module dc_lane (
    input  logic [31:0] word_i,
    input  logic [1:0]  off_i,
    input  logic [1:0]  size_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rd_o,
    output logic [31:0] merged_o,
    output logic [3:0]  be_o,
    output logic [31:0] lane_o
);
    import dc_pkg::*;

    logic [31:0] shifted;

    always_comb begin
        // big-endian: offset 0 is the most significant byte
        shifted = word_i >> {~off_i, 3'b000};
        case (size_i)
            SZ_BYTE: begin
                be_o   = 4'b1000 >> off_i;
                rd_o   = {24'h0, shifted[7:0]};
                lane_o = {4{wdata_i[7:0]}};
            end
            SZ_HALF: begin
                be_o   = off_i[1] ? 4'b0011 : 4'b1100;
                rd_o   = off_i[1] ? {16'h0, word_i[15:0]} : {16'h0, word_i[31:16]};
                lane_o = {2{wdata_i[15:0]}};
            end
            default: begin
                be_o   = 4'b1111;
                rd_o   = word_i;
                lane_o = wdata_i;
            end
        endcase
        for (int i = 0; i < 4; i++) begin
            merged_o[8*i +: 8] = be_o[i] ? lane_o[8*i +: 8] : word_i[8*i +: 8];
        end
    end
endmodule

// File: rtl/dc_age.sv
module dc_age #(
    parameter int SETS    = 4,
    parameter int WAYS    = 2,
    parameter int USTATES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [IDX_W-1:0]        set_i,
    input  logic [WAY_W-1:0]        way_i,
    input  logic                    touch_i,
    input  logic                    fill_i,
    input  logic                    kill_i,
    input  logic                    kill_all_i,
    output logic [WAY_W-1:0]        victim_o
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int AGE_W = $clog2(USTATES);
    localparam logic [AGE_W-1:0] TOP = AGE_W'(USTATES - 1);

    logic [SETS-1:0][WAYS-1:0][AGE_W-1:0] age_q, age_d;
    logic [WAYS-1:0][AGE_W-1:0] row;
    logic [AGE_W-1:0] minv;

    always_comb begin
        age_d    = age_q;
        row      = age_q[set_i];
        minv     = TOP;
        victim_o = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (row[i] < minv) begin
                victim_o = WAY_W'(i);
                minv     = row[i];
            end
        end
        if (touch_i) begin
            for (int i = 0; i < WAYS; i++) begin
                if (row[i] > row[way_i]) age_d[set_i][i] = row[i] - 1'b1;
            end
            age_d[set_i][way_i] = TOP;
        end else if (fill_i) begin
            for (int i = 0; i < WAYS; i++) begin
                if (row[i] != '0) age_d[set_i][i] = row[i] - 1'b1;
            end
            age_d[set_i][way_i] = TOP;
        end else if (kill_i) begin
            age_d[set_i][way_i] = '0;
        end else if (kill_all_i) begin
            age_d[set_i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R8: a used way is the youngest afterwards
    p_touch_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_i || fill_i) |=> age_q[$past(set_i)][$past(way_i)] == TOP);

    // R9 / R10: a cleared way drops to age zero
    p_kill_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_i && !touch_i && !fill_i) |=> age_q[$past(set_i)][$past(way_i)] == '0);
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int LINE_WORDS = 4,
    parameter int USTATES    = 4,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_present,
    input  logic             cfg_enable,
    input  logic             cpu_req,
    input  logic             cpu_we,
    input  logic [1:0]       cpu_size,
    input  logic [31:0]      cpu_addr,
    input  logic [31:0]      cpu_wdata,
    input  logic             cpu_nocache,
    input  logic             cpu_inv,
    output logic             cpu_ready,
    output logic [31:0]      cpu_rdata,
    output logic             cpu_err,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [3:0]       mem_be,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err,
    output logic [CNT_W-1:0] cnt_rd_hit,
    output logic [CNT_W-1:0] cnt_rd_miss,
    output logic [CNT_W-1:0] cnt_wr_hit,
    output logic [CNT_W-1:0] cnt_wr_miss
);
    import dc_pkg::*;

    localparam int WIDX_W = $clog2(LINE_WORDS);
    localparam int OFF_W  = WIDX_W + 2;
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = 32 - OFF_W - IDX_W;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [WIDX_W-1:0] LAST = WIDX_W'(LINE_WORDS - 1);

    typedef struct packed {
        dc_state_e                                   st;
        logic [31:0]                                 addr;
        logic                                        we;
        logic [1:0]                                  size;
        logic [31:0]                                 wdata;
        logic                                        nc;
        logic                                        inv;
        logic [WAY_W-1:0]                            vic;
        logic [WIDX_W-1:0]                           k;
        logic [31:0]                                 rdata;
        logic                                        err;
        logic [SETS-1:0][WAYS-1:0]                   valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]        tag;
        logic [SETS-1:0][WAYS-1:0][LINE_WORDS-1:0][31:0] data;
        logic [CNT_W-1:0]                            rh;
        logic [CNT_W-1:0]                            rm;
        logic [CNT_W-1:0]                            wh;
        logic [CNT_W-1:0]                            wm;
    } st_t;

    st_t q, d;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag_a;
    logic [WIDX_W-1:0] widx, fidx;
    logic              cacheable, hit;
    logic [WAY_W-1:0]  hway, victim, age_way;
    logic [31:0]       hit_word, lane_word, lane_rd, lane_merged, lane_data;
    logic [3:0]        lane_be;
    logic              touch, fill, kill, kill_all;

    // address split and tag lookup
    always_comb begin
        idx       = q.addr[OFF_W +: IDX_W];
        tag_a     = q.addr[31 -: TAG_W];
        widx      = q.addr[2 +: WIDX_W];
        fidx      = widx + q.k;
        cacheable = cfg_present & cfg_enable & ~q.nc;
        hit       = 1'b0;
        hway      = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (q.valid[idx][w] && q.tag[idx][w] == tag_a) begin
                hit  = 1'b1;
                hway = WAY_W'(w);
            end
        end
        hit_word  = q.data[idx][hway][widx];
        lane_word = (q.st == ST_LOOK) ? hit_word : mem_rdata;
    end

    dc_lane u_lane (
        .word_i   (lane_word),
        .off_i    (q.addr[1:0]),
        .size_i   (q.size),
        .wdata_i  (q.wdata),
        .rd_o     (lane_rd),
        .merged_o (lane_merged),
        .be_o     (lane_be),
        .lane_o   (lane_data)
    );

    dc_age #(.SETS(SETS), .WAYS(WAYS), .USTATES(USTATES)) u_age (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (idx),
        .way_i      (age_way),
        .touch_i    (touch),
        .fill_i     (fill),
        .kill_i     (kill),
        .kill_all_i (kill_all),
        .victim_o   (victim)
    );

    always_comb begin
        d         = q;
        touch     = 1'b0;
        fill      = 1'b0;
        kill      = 1'b0;
        kill_all  = 1'b0;
        age_way   = hway;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {q.addr[31:2], 2'b00};
        mem_be    = lane_be;
        mem_wdata = lane_data;
        case (q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    d.addr  = cpu_addr;
                    d.we    = cpu_we;
                    d.size  = cpu_size;
                    d.wdata = cpu_wdata;
                    d.nc    = cpu_nocache;
                    d.inv   = cpu_inv;
                    d.rdata = '0;
                    d.err   = 1'b0;
                    d.st    = ST_DISP;
                end
            end
            ST_DISP: begin
                if (q.inv) begin
                    if (cfg_present && !cfg_enable) begin
                        kill_all     = 1'b1;
                        d.valid[idx] = '0;
                    end else if (cfg_present && hit) begin
                        kill               = 1'b1;
                        d.valid[idx][hway] = 1'b0;
                    end
                    d.st = ST_DONE;
                end else if (q.we) begin
                    d.st = ST_MEMWR;
                end else if (cacheable) begin
                    d.st = ST_LOOK;
                end else begin
                    d.st = ST_MEMRD;
                end
            end
            ST_MEMRD: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    d.rdata = mem_err ? '0 : lane_rd;
                    d.err   = mem_err;
                    d.st    = ST_DONE;
                end
            end
            ST_MEMWR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ack) begin
                    d.err = mem_err;
                    d.st  = (!mem_err && cacheable) ? ST_LOOK : ST_DONE;
                end
            end
            ST_LOOK: begin
                if (hit) begin
                    touch = 1'b1;
                    if (q.we) begin
                        d.data[idx][hway][widx] = lane_merged;
                        d.wh = q.wh + CNT_W'(1);
                    end else begin
                        d.rdata = lane_rd;
                        d.rh    = q.rh + CNT_W'(1);
                    end
                    d.st = ST_DONE;
                end else begin
                    if (q.we) d.wm = q.wm + CNT_W'(1);
                    else      d.rm = q.rm + CNT_W'(1);
                    d.vic = victim;
                    d.k   = '0;
                    d.st  = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {q.addr[31:OFF_W], fidx, 2'b00};
                age_way  = q.vic;
                if (mem_ack) begin
                    if (mem_err) begin
                        d.valid[idx][q.vic] = 1'b0;
                        kill    = 1'b1;
                        d.err   = 1'b1;
                        d.rdata = '0;
                        d.st    = ST_DONE;
                    end else begin
                        d.data[idx][q.vic][fidx] = mem_rdata;
                        if (q.k == '0 && !q.we) d.rdata = lane_rd;
                        if (q.k == LAST) begin
                            d.tag[idx][q.vic]   = tag_a;
                            d.valid[idx][q.vic] = 1'b1;
                            fill = 1'b1;
                            d.st = ST_DONE;
                        end else begin
                            d.k = q.k + 1'b1;
                        end
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpu_ready   = (q.st == ST_DONE);
    assign cpu_rdata   = q.rdata;
    assign cpu_err     = q.err;
    assign cnt_rd_hit  = q.rh;
    assign cnt_rd_miss = q.rm;
    assign cnt_wr_hit  = q.wh;
    assign cnt_wr_miss = q.wm;

    p_ready_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_err) |-> (cpu_rdata == '0));

    p_write_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) >= 1));

    p_wrap_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && mem_ack && !mem_err && q.k != LAST) |=>
        (mem_addr[OFF_W-1:2] == WIDX_W'($past(mem_addr[OFF_W-1:2]) + 1'b1)));
endmodule

// File: tb/sim_dcache_wt.sv
module sim_dcache_wt;
    localparam int SETS = 4;
    localparam int WAYS = 2;
    localparam int LW   = 4;
    localparam int US   = 4;
    localparam int CW   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_present = 1'b1, cfg_enable = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_nocache = 1'b0, cpu_inv = 1'b0;
    logic [1:0] cpu_size = 2'd2;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic cpu_ready, cpu_err, mem_req, mem_we;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic [3:0] mem_be;
    logic mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [CW-1:0] cnt_rd_hit, cnt_rd_miss, cnt_wr_hit, cnt_wr_miss;

    always #2 clk = ~clk;

    dcache_wt #(.SETS(SETS), .WAYS(WAYS), .LINE_WORDS(LW), .USTATES(US), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_present(cfg_present), .cfg_enable(cfg_enable),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_nocache(cpu_nocache), .cpu_inv(cpu_inv),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_err(cpu_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .cnt_rd_hit(cnt_rd_hit), .cnt_rd_miss(cnt_rd_miss),
        .cnt_wr_hit(cnt_wr_hit), .cnt_wr_miss(cnt_wr_miss));

    int checks = 0;
    int errors = 0;

    // external memory and its access log
    logic [31:0] memw [int];
    int err_wa = -1;
    logic [31:0] act_log[$];
    logic [31:0] exp_log[$];

    function automatic logic [31:0] memrd(int wa);
        if (memw.exists(wa)) return memw[wa];
        return (32'(wa) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    // reference model state
    logic [31:0] m_tag [SETS][WAYS];
    bit          m_val [SETS][WAYS];
    int          m_age [SETS][WAYS];
    logic [31:0] m_dat [SETS][WAYS][LW];
    int c_rh = 0, c_rm = 0, c_wh = 0, c_wm = 0;

    function automatic logic [31:0] ext(logic [31:0] w, logic [1:0] off, logic [1:0] sz);
        if (sz == 2'd0) return (w >> (8 * (3 - int'(off)))) & 32'hFF;
        if (sz == 2'd1) return off[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
        return w;
    endfunction

    function automatic logic [31:0] mrg(logic [31:0] w, logic [1:0] off, logic [1:0] sz, logic [31:0] v);
        int pos;
        if (sz == 2'd0) begin
            pos = 8 * (3 - int'(off));
            return (w & ~(32'hFF << pos)) | ((v & 32'hFF) << pos);
        end
        if (sz == 2'd1) return off[1] ? {w[31:16], v[15:0]} : {v[15:0], w[15:0]};
        return v;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_val[s][w] = 0; m_age[s][w] = 0; m_tag[s][w] = '0;
            end
    end

    // memory responder: one word at a time, acknowledge for one cycle
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_req) begin
                int wa;
                logic [31:0] cur;
                wa = int'(mem_addr >> 2);
                act_log.push_back(mem_addr);
                mem_ack = 1'b1;
                mem_err = (wa == err_wa);
                if (mem_err) begin
                    mem_rdata = 32'hDEADBEEF;
                end else if (mem_we) begin
                    cur = memrd(wa);
                    for (int i = 0; i < 4; i++)
                        if (mem_be[i]) cur[8*i +: 8] = mem_wdata[8*i +: 8];
                    memw[wa] = cur;
                end else begin
                    mem_rdata = memrd(wa);
                end
            end
        end
    end

    // refill in the model; returns 1 on bus error
    function automatic bit m_refill(int s, logic [31:0] t, logic [31:0] a);
        int v, minv, wi, base, wa, pos;
        minv = US - 1; v = 0;
        for (int i = 0; i < WAYS; i++)
            if (m_age[s][i] < minv) begin v = i; minv = m_age[s][i]; end
        wi = int'(a >> 2) % LW;
        base = int'(a >> 2) - wi;
        for (int k = 0; k < LW; k++) begin
            pos = (wi + k) % LW;
            wa = base + pos;
            exp_log.push_back(32'(wa) << 2);
            if (wa == err_wa) begin
                m_val[s][v] = 0; m_age[s][v] = 0;
                return 1;
            end
            m_dat[s][v][pos] = memrd(wa);
        end
        m_tag[s][v] = t; m_val[s][v] = 1;
        for (int i = 0; i < WAYS; i++) if (m_age[s][i] != 0) m_age[s][i]--;
        m_age[s][v] = US - 1;
        return 0;
    endfunction

    function automatic int m_find(int s, logic [31:0] t);
        int h = -1;
        for (int i = 0; i < WAYS; i++) if (m_val[s][i] && m_tag[s][i] == t) h = i;
        return h;
    endfunction

    function automatic void m_touch(int s, int h);
        int ha = m_age[s][h];
        for (int i = 0; i < WAYS; i++) if (m_age[s][i] > ha) m_age[s][i]--;
        m_age[s][h] = US - 1;
    endfunction

    task automatic m_run(bit we, logic [1:0] sz, logic [31:0] a, logic [31:0] wd, bit nc, bit inv,
                         output logic [31:0] r, output bit e);
        int s, h, wi;
        logic [31:0] t;
        bit cach;
        cach = cfg_present && cfg_enable && !nc;
        s  = int'(a / (LW * 4)) % SETS;
        t  = (a / (LW * 4)) / SETS;
        wi = int'(a >> 2) % LW;
        r = '0; e = 0;
        if (inv) begin
            if (cfg_present && !cfg_enable) begin
                for (int i = 0; i < WAYS; i++) begin m_val[s][i] = 0; m_age[s][i] = 0; end
            end else if (cfg_present) begin
                h = m_find(s, t);
                if (h >= 0) begin m_val[s][h] = 0; m_age[s][h] = 0; end
            end
        end else if (we) begin
            exp_log.push_back({a[31:2], 2'b00});
            if (int'(a >> 2) == err_wa) e = 1;
            else if (cach) begin
                h = m_find(s, t);
                if (h >= 0) begin
                    c_wh++;
                    m_dat[s][h][wi] = mrg(m_dat[s][h][wi], a[1:0], sz, wd);
                    m_touch(s, h);
                end else begin
                    c_wm++;
                    e = m_refill(s, t, a);
                end
            end
        end else if (!cach) begin
            exp_log.push_back({a[31:2], 2'b00});
            if (int'(a >> 2) == err_wa) e = 1;
            else r = ext(memrd(int'(a >> 2)), a[1:0], sz);
        end else begin
            h = m_find(s, t);
            if (h >= 0) begin
                c_rh++;
                r = ext(m_dat[s][h][wi], a[1:0], sz);
                m_touch(s, h);
            end else begin
                c_rm++;
                e = m_refill(s, t, a);
                if (!e) begin
                    h = m_find(s, t);
                    r = ext(m_dat[s][h][wi], a[1:0], sz);
                end
            end
        end
    endtask

    logic [31:0] last_rdata;

    task automatic access(bit we, logic [1:0] sz, logic [31:0] a, logic [31:0] wd,
                          bit nc, bit inv, string req);
        logic [31:0] er;
        bit ee;
        logic [31:0] ar;
        bit ae;
        @(negedge clk);
        act_log.delete();
        exp_log.delete();
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a;
        cpu_wdata = wd; cpu_nocache = nc; cpu_inv = inv;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        ar = cpu_rdata; ae = cpu_err;
        cpu_req = 1'b0;
        last_rdata = ar;
        m_run(we, sz, a, wd, nc, inv, er, ee);
        if (!we && !inv) chk(ar == er, req, "load data", ar, er);
        chk(ae == ee, req, "error flag", 32'(ae), 32'(ee));
        chk(act_log.size() == exp_log.size(), req, "memory access count",
            32'(act_log.size()), 32'(exp_log.size()));
        for (int i = 0; i < exp_log.size() && i < act_log.size(); i++)
            chk(act_log[i] == exp_log[i], req, "memory address order", act_log[i], exp_log[i]);
        @(negedge clk);
        // R11: counters
        chk(cnt_rd_hit  == CW'(c_rh), "R11", "read hits",    32'(cnt_rd_hit),  32'(c_rh));
        chk(cnt_rd_miss == CW'(c_rm), "R11", "read misses",  32'(cnt_rd_miss), 32'(c_rm));
        chk(cnt_wr_hit  == CW'(c_wh), "R11", "write hits",   32'(cnt_wr_hit),  32'(c_wh));
        chk(cnt_wr_miss == CW'(c_wm), "R11", "write misses", 32'(cnt_wr_miss), 32'(c_wm));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R12 watchdog expired actual=%08h expected=%08h", 32'(0), 32'(1));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R12", "ready after reset", 32'(cpu_ready), 0);
        chk(mem_req == 1'b0, "R12", "mem_req after reset", 32'(mem_req), 0);
        chk(cnt_rd_hit == '0 && cnt_wr_miss == '0, "R11", "counters after reset", 32'(cnt_rd_hit), 0);

        access(0, 2'd2, 32'h100, 0, 0, 0, "R6");      // miss, refill from word 0
        access(0, 2'd0, 32'h10B, 0, 0, 0, "R4");      // byte hit, lowest lane
        access(0, 2'd1, 32'h10E, 0, 0, 0, "R4");      // halfword hit, low half
        access(0, 2'd0, 32'h100, 0, 0, 0, "R4");      // byte at offset 0
        saved = memrd(32'h108 >> 2);
        memw[32'h108 >> 2] = 32'hCAFEF00D;            // backdoor change
        access(0, 2'd2, 32'h108, 0, 0, 0, "R1");
        chk(last_rdata == saved, "R1", "stale cached word", last_rdata, saved);
        access(0, 2'd2, 32'h20C, 0, 0, 0, "R6");      // refill wraps from last word
        access(0, 2'd2, 32'h104, 0, 0, 0, "R8");      // hit ages
        access(0, 2'd2, 32'h30C, 0, 0, 0, "R7");      // third tag evicts oldest
        access(0, 2'd2, 32'h208, 0, 0, 0, "R7");
        access(0, 2'd2, 32'h104, 0, 0, 0, "R8");
        access(1, 2'd0, 32'h101, 32'h000000A5, 0, 0, "R5");
        access(0, 2'd2, 32'h100, 0, 0, 0, "R5");
        access(1, 2'd1, 32'h412, 32'h00001234, 0, 0, "R7"); // write miss allocates
        access(0, 2'd2, 32'h410, 0, 0, 0, "R3");
        access(1, 2'd1, 32'h410, 32'h0000BEEF, 0, 0, "R5");
        access(0, 2'd2, 32'h410, 0, 0, 0, "R5");
        access(1, 2'd2, 32'h104, 32'h11223344, 1, 0, "R2"); // no-cache store
        access(0, 2'd2, 32'h104, 0, 1, 0, "R2");
        access(0, 2'd2, 32'h104, 0, 0, 0, "R2");
        cfg_enable = 1'b0;
        access(0, 2'd1, 32'h30C, 0, 0, 0, "R2");
        access(1, 2'd0, 32'h30D, 32'h77, 0, 0, "R2");
        cfg_enable = 1'b1;
        access(0, 2'd2, 32'h30C, 0, 0, 0, "R2");
        access(0, 2'd2, 32'h30C, 0, 0, 1, "R10");     // enabled: matching way only
        access(0, 2'd2, 32'h30C, 0, 0, 0, "R10");
        access(0, 2'd2, 32'h100, 0, 0, 0, "R10");
        cfg_enable = 1'b0;
        access(0, 2'd2, 32'h000, 0, 0, 1, "R10");     // disabled: whole set
        cfg_enable = 1'b1;
        access(0, 2'd2, 32'h100, 0, 0, 0, "R10");
        cfg_present = 1'b0;
        access(0, 2'd2, 32'h100, 0, 0, 1, "R10");     // absent: nothing
        access(0, 2'd2, 32'h208, 0, 0, 0, "R2");
        cfg_present = 1'b1;
        access(0, 2'd2, 32'h100, 0, 0, 0, "R10");
        err_wa = 32'h504 >> 2;
        access(0, 2'd0, 32'h502, 0, 0, 0, "R9");      // error mid-refill
        err_wa = -1;
        access(0, 2'd0, 32'h502, 0, 0, 0, "R9");
        err_wa = 32'h508 >> 2;
        access(0, 2'd2, 32'h508, 0, 1, 0, "R9");      // bypass load error
        err_wa = 32'h600 >> 2;
        access(1, 2'd2, 32'h600, 32'h99, 0, 0, "R3"); // store write error
        err_wa = -1;
        access(0, 2'd2, 32'h600, 0, 0, 0, "R3");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            logic [1:0] sz;
            int p;
            sz = 2'($urandom_range(0, 2));
            a  = 32'($urandom_range(0, 1023));
            if (sz == 2'd1) a[0] = 1'b0;
            if (sz == 2'd2) a[1:0] = 2'b00;
            p = $urandom_range(0, 99);
            if (p < 4) cfg_enable = ~cfg_enable;
            if (p == 50) err_wa = int'(a >> 2); else err_wa = -1;
            access(p < 40, sz, a, $urandom, (p % 13) == 0, (p % 29) == 3, "R7");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule